// File: doc/BRIEF.md
# DMA Remapping Fault Recorder

This block stores address-translation faults reported by a DMA remapping unit. Faults are kept in a small bank of recording slots so that software can inspect them later. The general remapping engine owns eight slots. A separate isochronous engine owns one slot. Each engine has its own fault input. A slot holds a valid flag, an 8-bit reason code, a 16-bit requester ID and the 4 KB page address of the faulting access.

A new fault from a requester that no valid slot holds goes to the lowest-numbered free slot. A fault from a requester that a valid slot already holds is absorbed, so the slot keeps its first fault. When every slot of an engine is valid, the engine's overflow flag is set and the fault is dropped. Software reads slots and the overflow flags through a simple register port. Writing a one to a flag clears it.

Each engine bank runs a two-state machine, IDLE and RETRY. The transitions are:
- **defer** (IDLE to RETRY): a fault targets a slot that software clears in the same cycle. The fault is parked in a hold register.
- **requeue** (RETRY to RETRY): the held fault is processed and a newly arriving fault takes its place in the hold register.
- **re-defer** (RETRY to RETRY): the held fault collides with a clear again. It stays held, and a fault arriving in that cycle is dropped and flags overflow.
- **drain** (RETRY to IDLE): the held fault is processed and nothing new arrives.

A functional soft reset returns the machine to IDLE. A separate power-on reset is the only thing that clears the stored slots and flags.

Top module: `fr_recorder`

## Requirements
- R1: After power-on reset, a read of every address 0 to 9 returns all zeros.
- R2: A fault whose requester matches no valid slot of its engine is stored in that engine's lowest-numbered free slot, readable after the next clock edge. Address mapping: general slots sit at addresses 0 to 7 and the isochronous slot at address 8. Record layout: bit 127 is the valid flag, bits 103:96 the reason, bits 79:64 the requester ID, bits 63:12 the page address.
- R3: Every record bit outside those fields reads zero, and a slot whose valid flag is clear reads as all zeros.
- R4: A fault whose requester equals that of a valid slot of the same engine is dropped. It takes no slot and sets no overflow, also when all slots are valid.
- R5: While a slot stays valid, its reason, requester and page fields keep the first fault's values.
- R6: A write to a slot address with bit 127 set clears that slot's valid flag. A write with bit 127 clear changes nothing, and the other written bits are ignored. A freed slot is reused by the next new fault.
- R7: The status word is at address 9. Bit 0 is the general overflow flag, bit 1 the isochronous overflow flag, and the higher bits read zero. A flag is set when a non-matching fault finds all of its engine's slots valid; that fault is dropped. Writing a one to a flag bit clears it, but a same-cycle set wins over the clear.
- R8: The isochronous engine is independent. Its faults fill only address 8 and flag only bit 1. Clearing its slot or flag leaves the general engine's state untouched.
- R9: While soft reset is asserted, fault inputs are ignored. Stored records and overflow flags keep their values through it.
- R10: When a fault's target slot is cleared by software in the same cycle, the clear wins and the fault is stored one cycle later against the updated slots. A fault that arrives during that retry cycle is held and stored one cycle after the retried one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on reset, active low, clears everything |
| soft_rst_n | input | 1 | Functional reset, active low, resets only the retry machines |
| gen_flt_vld | input | 1 | General engine fault strobe |
| gen_flt_rsn | input | 8 | General fault reason code |
| gen_flt_sid | input | 16 | General fault requester ID |
| gen_flt_page | input | 52 | General fault page address (address bits 63:12) |
| iso_flt_vld | input | 1 | Isochronous engine fault strobe |
| iso_flt_rsn | input | 8 | Isochronous fault reason code |
| iso_flt_sid | input | 16 | Isochronous fault requester ID |
| iso_flt_page | input | 52 | Isochronous fault page address |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 128 | Register write data |
| reg_rdata | output | 128 | Register read data for reg_addr, combinational |

## Verification
The assertions check the following on every cycle:
- at most one general slot is allocated per cycle, and only in response to a fault input or a held retry;
- reserved read bits stay zero, and invalid slots read as zero;
- a valid slot's fields stay frozen;
- a write-one clear takes effect at the next edge;
- the overflow flag rises only with a full bank or a retry collision, never on a matching requester;
- soft reset leaves the valid flags alone.

Only the bench scenarios can show the following:
- lowest-free placement order;
- exact field placement of captured values;
- the one-cycle retry after a clear collision, and the extra cycle for a fault queued behind it;
- overflow set winning over a same-cycle clear;
- isolation between the two engines.

// File: rtl/fr_pkg.sv
package fr_pkg;

    localparam int RSN_W     = 8;
    localparam int SID_W     = 16;
    localparam int PAGE_W    = 52;
    localparam int REC_W     = 128;
    localparam int GEN_SLOTS = 8;
    localparam int ISO_SLOTS = 1;
    localparam int ADDR_W    = 4;

    // Record field positions (software decodes these)
    localparam int VLD_BIT  = 127;
    localparam int RSN_LSB  = 96;
    localparam int SID_LSB  = 64;
    localparam int PAGE_LSB = 12;

    // Status word bit positions
    localparam int GEN_OVF_BIT = 0;
    localparam int ISO_OVF_BIT = 1;

    typedef struct packed {
        logic [RSN_W-1:0]  rsn;
        logic [SID_W-1:0]  sid;
        logic [PAGE_W-1:0] page;
    } fault_t;

    typedef enum logic [0:0] {
        BK_IDLE  = 1'b0,
        BK_RETRY = 1'b1
    } bank_st_e;

    // Build a readable record; an invalid slot reads as zero (R3)
    function automatic logic [REC_W-1:0] pack_rec(input logic vld, input fault_t f);
        logic [REC_W-1:0] r;
        r = '0;
        if (vld) begin
            r[VLD_BIT]                = 1'b1;
            r[RSN_LSB +: RSN_W]       = f.rsn;
            r[SID_LSB +: SID_W]       = f.sid;
            r[PAGE_LSB +: PAGE_W]     = f.page;
        end
        return r;
    endfunction

endpackage

// File: rtl/fr_pick.sv
// Lowest-index one-hot picker
module fr_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] oh,
    output logic         any
);
    assign oh  = req & (~req + N'(1));
    assign any = |req;
endmodule

// File: rtl/fr_bank.sv
// One engine's slot bank with its collision-retry state machine
module fr_bank
    import fr_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           por_rst_n,
    input  logic           soft_rst_n,
    input  logic           flt_vld,
    input  fault_t         flt_in,
    input  logic [N-1:0]   clr_mask,
    input  logic           ovf_clr,
    output logic [N-1:0]   slot_vld,
    output fault_t [N-1:0] slot_rec,
    output logic           ovf,
    output logic           busy
);

    logic [N-1:0]   vld_q;
    fault_t [N-1:0] rec_q;
    logic           ovf_q;
    bank_st_e       st_q, st_nx;
    fault_t         hold_q, hold_nx;

    logic           cand_vld;
    fault_t         cand;
    logic [N-1:0]   match_req, match_oh, free_oh, tgt_oh, cap_oh;
    logic           hit, free_any, full, conflict, capture, ovf_set;

    // Candidate selection: held fault has priority in RETRY
    always_comb begin
        cand_vld = 1'b0;
        cand     = flt_in;
        unique case (st_q)
            BK_IDLE: begin
                cand_vld = flt_vld;
                cand     = flt_in;
            end
            BK_RETRY: begin
                cand_vld = 1'b1;
                cand     = hold_q;
            end
        endcase
        cand_vld = cand_vld & soft_rst_n;
    end

    // Requester match against valid slots
    for (genvar i = 0; i < N; i++) begin : g_match
        assign match_req[i] = vld_q[i] && (rec_q[i].sid == cand.sid);
    end

    fr_pick #(.N(N)) u_match (.req(match_req), .oh(match_oh), .any(hit));
    fr_pick #(.N(N)) u_free  (.req(~vld_q),    .oh(free_oh),  .any(free_any));

    assign full     = !free_any;
    assign tgt_oh   = hit ? match_oh : free_oh;
    assign conflict = cand_vld && |(tgt_oh & clr_mask);
    assign capture  = cand_vld && !hit && !full && !conflict;
    assign cap_oh   = capture ? free_oh : '0;
    assign ovf_set  = soft_rst_n &&
                      ((cand_vld && full && !hit) ||
                       (st_q == BK_RETRY && conflict && flt_vld));

    // Next-state: defer, requeue, re-defer, drain
    always_comb begin
        st_nx   = BK_IDLE;
        hold_nx = hold_q;
        unique case (st_q)
            BK_IDLE: begin
                if (conflict) begin
                    st_nx   = BK_RETRY;   // defer
                    hold_nx = flt_in;
                end
            end
            BK_RETRY: begin
                if (conflict) begin
                    st_nx   = BK_RETRY;   // re-defer, newcomer dropped
                end else if (flt_vld) begin
                    st_nx   = BK_RETRY;   // requeue
                    hold_nx = flt_in;
                end else begin
                    st_nx   = BK_IDLE;    // drain
                end
            end
        endcase
    end

    // State register: functional reset returns to IDLE
    always_ff @(posedge clk or negedge por_rst_n) begin
        if (!por_rst_n) begin
            st_q   <= BK_IDLE;
            hold_q <= '0;
        end else if (!soft_rst_n) begin
            st_q   <= BK_IDLE;
        end else begin
            st_q   <= st_nx;
            hold_q <= hold_nx;
        end
    end

    // Sticky storage: only power-on reset clears it
    always_ff @(posedge clk or negedge por_rst_n) begin
        if (!por_rst_n) begin
            vld_q <= '0;
            rec_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            vld_q <= (vld_q | cap_oh) & ~clr_mask;
            ovf_q <= ovf_set | (ovf_q & ~ovf_clr);
            for (int i = 0; i < N; i++) begin
                if (cap_oh[i]) rec_q[i] <= cand;
            end
        end
    end

    assign slot_vld = vld_q;
    assign slot_rec = rec_q;
    assign ovf      = ovf_q;
    assign busy     = (st_q == BK_RETRY);

endmodule

// File: rtl/fr_recorder.sv
module fr_recorder
    import fr_pkg::*;
#(
    parameter int GEN_N = GEN_SLOTS,
    parameter int ISO_N = ISO_SLOTS,
    parameter int AW    = ADDR_W
) (
    input  logic              clk,
    input  logic              por_rst_n,
    input  logic              soft_rst_n,
    input  logic              gen_flt_vld,
    input  logic [RSN_W-1:0]  gen_flt_rsn,
    input  logic [SID_W-1:0]  gen_flt_sid,
    input  logic [PAGE_W-1:0] gen_flt_page,
    input  logic              iso_flt_vld,
    input  logic [RSN_W-1:0]  iso_flt_rsn,
    input  logic [SID_W-1:0]  iso_flt_sid,
    input  logic [PAGE_W-1:0] iso_flt_page,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [REC_W-1:0]  reg_wdata,
    output logic [REC_W-1:0]  reg_rdata
);

    localparam int ISO_BASE  = GEN_N;
    localparam int STAT_ADDR = GEN_N + ISO_N;

    fault_t              gen_in, iso_in;
    logic [GEN_N-1:0]    gen_clr, gen_vld;
    logic [ISO_N-1:0]    iso_clr, iso_vld;
    fault_t [GEN_N-1:0]  gen_rec;
    fault_t [ISO_N-1:0]  iso_rec;
    logic                gen_ovf, iso_ovf, gen_busy, iso_busy;
    logic                stat_wr;
    logic                unused_wdata;

    assign gen_in = {gen_flt_rsn, gen_flt_sid, gen_flt_page};
    assign iso_in = {iso_flt_rsn, iso_flt_sid, iso_flt_page};

    // Write-one-to-clear decode
    for (genvar i = 0; i < GEN_N; i++) begin : g_gclr
        assign gen_clr[i] = reg_wr && (reg_addr == AW'(i)) && reg_wdata[VLD_BIT];
    end
    for (genvar i = 0; i < ISO_N; i++) begin : g_iclr
        assign iso_clr[i] = reg_wr && (reg_addr == AW'(ISO_BASE + i)) && reg_wdata[VLD_BIT];
    end
    assign stat_wr      = reg_wr && (reg_addr == AW'(STAT_ADDR));
    assign unused_wdata = ^reg_wdata[VLD_BIT-1:ISO_OVF_BIT+1];

    fr_bank #(.N(GEN_N)) u_gen (
        .clk(clk), .por_rst_n(por_rst_n), .soft_rst_n(soft_rst_n),
        .flt_vld(gen_flt_vld), .flt_in(gen_in),
        .clr_mask(gen_clr), .ovf_clr(stat_wr && reg_wdata[GEN_OVF_BIT]),
        .slot_vld(gen_vld), .slot_rec(gen_rec), .ovf(gen_ovf), .busy(gen_busy)
    );

    fr_bank #(.N(ISO_N)) u_iso (
        .clk(clk), .por_rst_n(por_rst_n), .soft_rst_n(soft_rst_n),
        .flt_vld(iso_flt_vld), .flt_in(iso_in),
        .clr_mask(iso_clr), .ovf_clr(stat_wr && reg_wdata[ISO_OVF_BIT]),
        .slot_vld(iso_vld), .slot_rec(iso_rec), .ovf(iso_ovf), .busy(iso_busy)
    );

    // Read mux
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < GEN_N; i++) begin
            if (reg_addr == AW'(i)) reg_rdata = pack_rec(gen_vld[i], gen_rec[i]);
        end
        for (int i = 0; i < ISO_N; i++) begin
            if (reg_addr == AW'(ISO_BASE + i)) reg_rdata = pack_rec(iso_vld[i], iso_rec[i]);
        end
        if (reg_addr == AW'(STAT_ADDR)) begin
            reg_rdata[GEN_OVF_BIT] = gen_ovf;
            reg_rdata[ISO_OVF_BIT] = iso_ovf;
        end
    end

    logic unused_iso_busy;
    assign unused_iso_busy = iso_busy;

endmodule

// File: rtl/fr_recorder_chk.sv
module fr_recorder_chk
    import fr_pkg::*;
#(
    parameter int N    = GEN_SLOTS,
    parameter int AW   = ADDR_W,
    parameter int STAT = GEN_SLOTS + ISO_SLOTS
) (
    input logic              clk,
    input logic              por_rst_n,
    input logic              soft_rst_n,
    input logic              gen_flt_vld,
    input logic [SID_W-1:0]  gen_flt_sid,
    input logic              reg_wr,
    input logic [AW-1:0]     reg_addr,
    input logic              wbit,
    input logic [REC_W-1:0]  reg_rdata,
    input logic [N-1:0]      g_vld,
    input fault_t [N-1:0]    g_rec,
    input logic              g_ovf,
    input logic              g_busy
);

    logic [N-1:0] clr_dec, hit_vec;
    logic [REC_W-1:0] rsv_mask;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            clr_dec[i] = reg_wr && wbit && (reg_addr == AW'(i));
            hit_vec[i] = g_vld[i] && (g_rec[i].sid == gen_flt_sid);
        end
        rsv_mask = '1;
        rsv_mask[VLD_BIT]              = 1'b0;
        rsv_mask[RSN_LSB +: RSN_W]     = '0;
        rsv_mask[SID_LSB +: SID_W]     = '0;
        rsv_mask[PAGE_LSB +: PAGE_W]   = '0;
    end

    assert_one_alloc_R2: assert property (@(posedge clk) disable iff (!por_rst_n)
        $countones(g_vld & ~$past(g_vld)) <= 1);

    assert_alloc_cause_R2: assert property (@(posedge clk) disable iff (!por_rst_n)
        (|(g_vld & ~$past(g_vld))) |-> ($past(gen_flt_vld) || $past(g_busy)));

    assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!por_rst_n)
        (reg_addr < AW'(STAT)) |-> ((reg_rdata & rsv_mask) == '0));

    assert_invalid_zero_R3: assert property (@(posedge clk) disable iff (!por_rst_n)
        ((reg_addr < AW'(STAT)) && !reg_rdata[VLD_BIT]) |-> (reg_rdata == '0));

    assert_stat_upper_zero_R7: assert property (@(posedge clk) disable iff (!por_rst_n)
        (reg_addr == AW'(STAT)) |-> (reg_rdata[REC_W-1:ISO_OVF_BIT+1] == '0));

    assert_collapse_no_ovf_R4: assert property (@(posedge clk) disable iff (!por_rst_n)
        (gen_flt_vld && soft_rst_n && !g_busy && (|hit_vec)) |=> !$rose(g_ovf));

    assert_w1c_R6: assert property (@(posedge clk) disable iff (!por_rst_n)
        (|clr_dec) |=> ((g_vld & $past(clr_dec)) == '0));

    assert_ovf_cause_R7: assert property (@(posedge clk) disable iff (!por_rst_n)
        $rose(g_ovf) |-> ($past(&g_vld) || $past(g_busy)));

    assert_soft_keep_R9: assert property (@(posedge clk) disable iff (!por_rst_n)
        (!soft_rst_n && !reg_wr) |=> (g_vld == $past(g_vld)));

    for (genvar i = 0; i < N; i++) begin : g_sticky
        assert_sticky_R5: assert property (@(posedge clk) disable iff (!por_rst_n)
            (g_vld[i] && $past(g_vld[i])) |-> (g_rec[i] == $past(g_rec[i])));
    end

endmodule

bind fr_recorder fr_recorder_chk #(.N(GEN_N), .AW(AW), .STAT(STAT_ADDR)) u_chk (
    .clk(clk), .por_rst_n(por_rst_n), .soft_rst_n(soft_rst_n),
    .gen_flt_vld(gen_flt_vld), .gen_flt_sid(gen_flt_sid),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .wbit(reg_wdata[127]),
    .reg_rdata(reg_rdata),
    .g_vld(gen_vld), .g_rec(gen_rec), .g_ovf(gen_ovf), .g_busy(gen_busy)
);

// File: tb/fr_recorder_bench.sv
module fr_recorder_bench;

    logic         clk = 1'b0;
    logic         por_rst_n, soft_rst_n;
    logic         gen_flt_vld, iso_flt_vld, reg_wr;
    logic [7:0]   gen_flt_rsn, iso_flt_rsn;
    logic [15:0]  gen_flt_sid, iso_flt_sid;
    logic [51:0]  gen_flt_page, iso_flt_page;
    logic [3:0]   reg_addr;
    logic [127:0] reg_wdata, reg_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    fr_recorder u_fr_recorder (
        .clk(clk), .por_rst_n(por_rst_n), .soft_rst_n(soft_rst_n),
        .gen_flt_vld(gen_flt_vld), .gen_flt_rsn(gen_flt_rsn),
        .gen_flt_sid(gen_flt_sid), .gen_flt_page(gen_flt_page),
        .iso_flt_vld(iso_flt_vld), .iso_flt_rsn(iso_flt_rsn),
        .iso_flt_sid(iso_flt_sid), .iso_flt_page(iso_flt_page),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    localparam logic [1:0] OP_IDLE = 2'd0, OP_GEN = 2'd1, OP_ISO = 2'd2, OP_WR = 2'd3;
    localparam logic [3:0] STAT = 4'd9;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  addr;
        logic [15:0] sid;
        logic [7:0]  rsn;
        logic        wbit;
        logic [3:0]  chk;
        logic        ev;
        logic [15:0] esid;
        logic [7:0]  ersn;   // at the status address, bits 1:0 hold the expected flags
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{OP_GEN,  4'd0, 16'h0101, 8'h11, 1'b0, 4'd0, 1'b1, 16'h0101, 8'h11, 4'd2},  // R2 first slot
        '{OP_GEN,  4'd0, 16'h0202, 8'h22, 1'b0, 4'd1, 1'b1, 16'h0202, 8'h22, 4'd2},  // R2 lowest free
        '{OP_GEN,  4'd0, 16'h0101, 8'h33, 1'b0, 4'd0, 1'b1, 16'h0101, 8'h11, 4'd5},  // R5 first kept
        '{OP_IDLE, 4'd0, 16'h0000, 8'h00, 1'b0, 4'd2, 1'b0, 16'h0000, 8'h00, 4'd4},  // R4 no new slot
        '{OP_WR,   4'd0, 16'h0000, 8'h00, 1'b0, 4'd0, 1'b1, 16'h0101, 8'h11, 4'd6},  // R6 zero write
        '{OP_WR,   4'd0, 16'h0000, 8'h00, 1'b1, 4'd0, 1'b0, 16'h0000, 8'h00, 4'd6},  // R6 clear, R3
        '{OP_GEN,  4'd0, 16'h0303, 8'h44, 1'b0, 4'd0, 1'b1, 16'h0303, 8'h44, 4'd6},  // R6 reuse
        '{OP_ISO,  4'd0, 16'h0909, 8'h55, 1'b0, 4'd8, 1'b1, 16'h0909, 8'h55, 4'd8},  // R8 iso slot
        '{OP_ISO,  4'd0, 16'h0A0A, 8'h66, 1'b0, STAT, 1'b0, 16'h0000, 8'h02, 4'd8},  // R8 iso flag
        '{OP_IDLE, 4'd0, 16'h0000, 8'h00, 1'b0, 4'd8, 1'b1, 16'h0909, 8'h55, 4'd5},  // R5 iso kept
        '{OP_GEN,  4'd0, 16'h1010, 8'h70, 1'b0, 4'd2, 1'b1, 16'h1010, 8'h70, 4'd2},
        '{OP_GEN,  4'd0, 16'h1111, 8'h71, 1'b0, 4'd3, 1'b1, 16'h1111, 8'h71, 4'd2},
        '{OP_GEN,  4'd0, 16'h1212, 8'h72, 1'b0, 4'd4, 1'b1, 16'h1212, 8'h72, 4'd2},
        '{OP_GEN,  4'd0, 16'h1313, 8'h73, 1'b0, 4'd5, 1'b1, 16'h1313, 8'h73, 4'd2},
        '{OP_GEN,  4'd0, 16'h1414, 8'h74, 1'b0, 4'd6, 1'b1, 16'h1414, 8'h74, 4'd2},
        '{OP_GEN,  4'd0, 16'h1515, 8'h75, 1'b0, 4'd7, 1'b1, 16'h1515, 8'h75, 4'd2},
        '{OP_GEN,  4'd0, 16'h1616, 8'h76, 1'b0, STAT, 1'b0, 16'h0000, 8'h03, 4'd7},  // R7 full
        '{OP_GEN,  4'd0, 16'h0202, 8'h77, 1'b0, 4'd1, 1'b1, 16'h0202, 8'h22, 4'd4},  // R4 full hit
        '{OP_WR,   STAT, 16'h0000, 8'h00, 1'b1, STAT, 1'b0, 16'h0000, 8'h00, 4'd7},  // R7 clear
        '{OP_WR,   4'd8, 16'h0000, 8'h00, 1'b1, 4'd8, 1'b0, 16'h0000, 8'h00, 4'd8},  // R8 iso clear
        '{OP_IDLE, 4'd0, 16'h0000, 8'h00, 1'b0, 4'd1, 1'b1, 16'h0202, 8'h22, 4'd8}   // R8 general kept
    };

    function automatic logic [51:0] pg(input logic [15:0] sid);
        return {sid, ~sid, sid, 4'h5};
    endfunction

    function automatic logic [127:0] mk(input logic v, input logic [15:0] sid, input logic [7:0] rsn);
        if (!v) return '0;
        return {1'b1, 23'b0, rsn, 16'b0, sid, pg(sid), 12'b0};
    endfunction

    task automatic idle_in();
        gen_flt_vld = 1'b0; iso_flt_vld = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic gen_flt(input logic [15:0] sid, input logic [7:0] rsn);
        gen_flt_vld = 1'b1; gen_flt_sid = sid; gen_flt_rsn = rsn; gen_flt_page = pg(sid);
    endtask

    task automatic iso_flt(input logic [15:0] sid, input logic [7:0] rsn);
        iso_flt_vld = 1'b1; iso_flt_sid = sid; iso_flt_rsn = rsn; iso_flt_page = pg(sid);
    endtask

    task automatic wr(input logic [3:0] a, input logic ones);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = ones ? '1 : '0;
    endtask

    task automatic check(input logic [3:0] a, input logic [127:0] exp, input string rq);
        reg_addr = a;
        #1;
        n_cmp++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr %0d actual %h expected %h", rq, a, reg_rdata, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_in();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired (all requirements) actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        por_rst_n = 1'b0; soft_rst_n = 1'b0; reg_addr = '0;
        gen_flt_sid = '0; gen_flt_rsn = '0; gen_flt_page = '0;
        iso_flt_sid = '0; iso_flt_rsn = '0; iso_flt_page = '0;
        idle_in();
        repeat (3) @(posedge clk);
        @(negedge clk);
        por_rst_n = 1'b1; soft_rst_n = 1'b1;

        // R1: everything reads zero after power-on reset
        for (int a = 0; a < 10; a++) check(4'(a), '0, "R1 reset");

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [127:0] exp;
            v = VECS[i];
            unique case (v.op)
                OP_GEN:  gen_flt(v.sid, v.rsn);
                OP_ISO:  iso_flt(v.sid, v.rsn);
                OP_WR:   wr(v.addr, v.wbit);
                default: ;
            endcase
            step();
            exp = (v.chk == STAT) ? {126'b0, v.ersn[1:0]} : mk(v.ev, v.esid, v.ersn);
            check(v.chk, exp, $sformatf("R%0d vector %0d", v.req, i));
        end

        // R10: clear collides with a collapsing fault on slot 1
        gen_flt(16'h0202, 8'h88);
        wr(4'd1, 1'b1);
        step();
        check(4'd1, '0, "R10 clear wins");
        step();
        check(4'd1, mk(1'b1, 16'h0202, 8'h88), "R10 retried fault stored");

        // R10: deferred fault followed by a queued fault
        wr(4'd2, 1'b1); step();
        wr(4'd3, 1'b1); step();
        gen_flt(16'h0D0D, 8'h91);
        wr(4'd2, 1'b1);
        step();
        gen_flt(16'h0E0E, 8'h92);
        check(4'd2, '0, "R10 deferred not yet stored");
        step();
        check(4'd2, mk(1'b1, 16'h0D0D, 8'h91), "R10 deferred lands");
        check(4'd3, '0, "R10 queued waits");
        step();
        check(4'd3, mk(1'b1, 16'h0E0E, 8'h92), "R10 queued lands");

        // R7: overflow set beats same-cycle clear
        gen_flt(16'h0F0F, 8'h93);
        wr(STAT, 1'b1);
        step();
        check(STAT, 128'd1, "R7 set wins over clear");

        // R9: soft reset keeps state, ignores faults
        soft_rst_n = 1'b0;
        iso_flt(16'h0C0C, 8'h94);
        step();
        step();
        soft_rst_n = 1'b1;
        check(4'd8, '0, "R9 fault ignored in soft reset");
        check(STAT, 128'd1, "R9 flag kept");
        check(4'd0, mk(1'b1, 16'h0303, 8'h44), "R9 record kept");

        // R1: power-on reset clears everything again
        por_rst_n = 1'b0;
        step();
        por_rst_n = 1'b1;
        for (int a = 0; a < 10; a++) check(4'(a), '0, "R1 second reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule